// File: doc/BRIEF.md
# Hall-Commutated H-Bridge Drive Controller

This block steers a single-winding, two-phase brushless fan motor through the four gate enables of an H-bridge. A high-side and a low-side enable are provided for each of the two winding terminals, called leg A and leg B. The inputs are a Hall comparator bit and a PWM command bit, both already synchronised to the clock. A global output enable comes from the sleep and locked-rotor logic, and a digital over-temperature flag comes from the thermal sensor.

The Hall bit is filtered by a persistence check. A new level must hold for a set number of clock cycles before it is accepted. The accepted, or conditioned, level selects the direction of the winding current. The PWM command chops only the low-side switch of the leg that sinks current. While the PWM command is low, both high-side switches conduct, so the winding current recirculates through the upper half of the bridge instead of decaying.

On each leg, a dead-time interval separates the turn-off of one switch from the turn-on of the other. The block also exports the conditioned Hall level, an open-drain pull-down enable for a tachometer line, and a one-cycle strobe on every accepted commutation.

Top module: `hbridge_drive`

## Requirements
- R1: While rst_n is low, all four switch enables are 0, hallCond is 0, commStrobe is 0 and tachPullLow is 1.
- R2: hallCond takes the value of hallIn only after hallIn has differed from hallCond at DEGLITCH_CYCLES consecutive rising clock edges. It changes at the last of those edges. A shorter excursion leaves hallCond unchanged.
- R3: commStrobe is 1 for exactly the one cycle in which hallCond holds its newly accepted value, and is 0 at all other times.
- R4: tachPullLow is 1 when hallCond is 0 (line pulled low) and 0 when hallCond is 1 (line released).
- R5: With drive enabled, hallCond = 1 and pwmIn = 1, the settled outputs are hiA = 1 and loB = 1, with loA = 0 and hiB = 0. Current flows from A to B.
- R6: With drive enabled, hallCond = 0 and pwmIn = 1, the settled outputs are hiB = 1 and loA = 1, with loB = 0 and hiA = 0. Current flows from B to A.
- R7: With drive enabled and pwmIn = 0, the settled outputs are hiA = 1 and hiB = 1, with both low sides 0. This holds for either direction.
- R8: If outEnable is 0 or thermalFault is 1 at a clock edge, all four enables are 0 after that edge.
- R9: A leg never has its high and low enables at 1 together. When one of them turns off, the other turns on no earlier than max(DEAD_CYCLES,1) clock edges later. With DEAD_CYCLES = 2, the second edge after the turn-off edge is the first one that can turn the other switch on.
- R10: If drive is re-enabled after a leg has been fully off for at least DEAD_CYCLES cycles, that leg resumes its R5 to R7 state at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hallIn | input | 1 | Synchronised Hall comparator bit (1: positive input above negative) |
| pwmIn | input | 1 | Synchronised PWM command bit |
| outEnable | input | 1 | Global drive enable from the sleep and locked-rotor logic |
| thermalFault | input | 1 | Over-temperature flag; hysteresis is applied by the sensor |
| hallCond | output | 1 | Deglitched Hall level |
| commStrobe | output | 1 | One-cycle pulse when hallCond changes |
| tachPullLow | output | 1 | Enable for the open-drain tachometer pull-down |
| hiA | output | 1 | Leg A high-side switch enable |
| loA | output | 1 | Leg A low-side switch enable |
| hiB | output | 1 | Leg B high-side switch enable |
| loB | output | 1 | Leg B low-side switch enable |

## Verification
The bench holds a Hall excursion for one cycle less than the filter length. A filter that is off by one would commutate on that excursion and emit a strobe. It also counts the exact edges to acceptance, which catches a filter that flips early, and it checks that the strobe is one cycle wide. Each PWM edge is checked cycle by cycle across the dead-time window. A design that swaps switches directly, or shortens the gap, shows both leg switches on, or the new switch on too early. Thermal fault and enable loss are each checked for all switches off after one edge and for an immediate restart afterwards. A mis-gated enable would either leave a switch conducting or restart late.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int LEG_A = 0;
  localparam int LEG_B = 1;
  localparam int NUM_LEGS = 2;

  // Strobes handed from the control module to the datapath
  typedef struct packed {
    logic commute;   // conditioned Hall level just changed
    logic dirAtoB;   // 1: current from leg A to leg B
    logic pwmHigh;   // PWM on-time
    logic driveEn;   // bridge allowed to conduct
  } driveCmd_t;
endpackage

// File: rtl/hbd_control.sv
module hbd_control
  import hbd_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 25
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hallIn,
  input  logic      pwmIn,
  input  logic      outEnable,
  input  logic      thermalFault,
  output logic      hallCond,
  output driveCmd_t cmd
);
  localparam int CW = $clog2(DEGLITCH_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEGLITCH_CYCLES - 1);

  logic [CW-1:0] persistCnt;
  logic          commuteQ;

  // Persistence filter: a new level must be seen at DEGLITCH_CYCLES edges in a row
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hallCond   <= 1'b0;
      persistCnt <= '0;
      commuteQ   <= 1'b0;
    end else begin
      commuteQ <= 1'b0;
      if (hallIn == hallCond) begin
        persistCnt <= '0;
      end else if (persistCnt == LAST) begin
        hallCond   <= hallIn;
        persistCnt <= '0;
        commuteQ   <= 1'b1;
      end else begin
        persistCnt <= persistCnt + 1'b1;
      end
    end
  end

  always_comb begin
    cmd.commute = commuteQ;
    cmd.dirAtoB = hallCond;
    cmd.pwmHigh = pwmIn;
    cmd.driveEn = outEnable & ~thermalFault;
  end
endmodule

// File: rtl/hbd_leg.sv
module hbd_leg #(
  parameter int DEAD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wantHi,
  input  logic wantLo,
  output logic hiOn,
  output logic loOn
);
  localparam int CW = $clog2(DEAD_CYCLES + 2);
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYCLES);
  localparam logic [CW:0]   NEED = (CW+1)'(DEAD_CYCLES);

  logic [CW-1:0] offCnt;   // completed cycles with both switches off, saturating
  logic          bothOff;
  logic          settled;

  always_comb begin
    bothOff = ~hiOn & ~loOn;
    settled = ({1'b0, offCnt} + (CW+1)'(1)) >= NEED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiOn   <= 1'b0;
      loOn   <= 1'b0;
      offCnt <= SAT;
    end else begin
      // turn-off is immediate
      if (hiOn) hiOn <= wantHi;
      if (loOn) loOn <= wantLo;
      // turn-on only from an idle leg that has waited out the dead time
      if (bothOff && settled) begin
        hiOn <= wantHi;
        loOn <= wantLo & ~wantHi;
      end
      if (!bothOff)          offCnt <= '0;
      else if (offCnt != SAT) offCnt <= offCnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbd_datapath.sv
module hbd_datapath
  import hbd_pkg::*;
#(
  parameter int DEAD_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  driveCmd_t           cmd,
  output logic [NUM_LEGS-1:0] hiOn,
  output logic [NUM_LEGS-1:0] loOn,
  output logic                commStrobe
);
  logic [NUM_LEGS-1:0] wantHi;
  logic [NUM_LEGS-1:0] wantLo;
  int srcLeg;
  int snkLeg;

  // Source leg keeps its high side on; sink leg chops its low side,
  // its high side fills the off-time for recirculation.
  always_comb begin
    wantHi = '0;
    wantLo = '0;
    srcLeg = cmd.dirAtoB ? LEG_A : LEG_B;
    snkLeg = cmd.dirAtoB ? LEG_B : LEG_A;
    if (cmd.driveEn) begin
      wantHi[srcLeg] = 1'b1;
      wantLo[snkLeg] = cmd.pwmHigh;
      wantHi[snkLeg] = ~cmd.pwmHigh;
    end
    commStrobe = cmd.commute;
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbd_leg #(.DEAD_CYCLES(DEAD_CYCLES)) i_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wantHi (wantHi[g]),
      .wantLo (wantLo[g]),
      .hiOn   (hiOn[g]),
      .loOn   (loOn[g])
    );
  end
endmodule

// File: rtl/hbridge_drive.sv
module hbridge_drive
  import hbd_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 25,
  parameter int DEAD_CYCLES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hallIn,
  input  logic pwmIn,
  input  logic outEnable,
  input  logic thermalFault,
  output logic hallCond,
  output logic commStrobe,
  output logic tachPullLow,
  output logic hiA,
  output logic loA,
  output logic hiB,
  output logic loB
);
  driveCmd_t           cmd;
  logic [NUM_LEGS-1:0] hiOn;
  logic [NUM_LEGS-1:0] loOn;

  hbd_control #(.DEGLITCH_CYCLES(DEGLITCH_CYCLES)) i_control (
    .clk          (clk),
    .rst_n        (rst_n),
    .hallIn       (hallIn),
    .pwmIn        (pwmIn),
    .outEnable    (outEnable),
    .thermalFault (thermalFault),
    .hallCond     (hallCond),
    .cmd          (cmd)
  );

  hbd_datapath #(.DEAD_CYCLES(DEAD_CYCLES)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .hiOn       (hiOn),
    .loOn       (loOn),
    .commStrobe (commStrobe)
  );

  assign tachPullLow = ~hallCond;
  assign hiA = hiOn[LEG_A];
  assign loA = loOn[LEG_A];
  assign hiB = hiOn[LEG_B];
  assign loB = loOn[LEG_B];
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int DEAD_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic hallIn,
  input logic outEnable,
  input logic thermalFault,
  input logic hallCond,
  input logic commStrobe,
  input logic hiA,
  input logic loA,
  input logic hiB,
  input logic loB
);
  p_leg_a_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiA && loA));
  p_leg_b_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiB && loB));
  p_dead_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((DEAD_CYCLES >= 2) && $fell(loA)) |=> !hiA);
  p_dead_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((DEAD_CYCLES >= 2) && $fell(hiB)) |=> !loB);
  p_strobe_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commStrobe |-> (hallCond != $past(hallCond)));
  p_change_has_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hallCond != $past(hallCond)) |-> commStrobe);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hallIn == hallCond) |=> $stable(hallCond));
  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!outEnable || thermalFault) |=> !(hiA || loA || hiB || loB));
endmodule

bind hbridge_drive hbd_checker #(.DEAD_CYCLES(DEAD_CYCLES)) i_hbd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .hallIn       (hallIn),
  .outEnable    (outEnable),
  .thermalFault (thermalFault),
  .hallCond     (hallCond),
  .commStrobe   (commStrobe),
  .hiA          (hiA),
  .loA          (loA),
  .hiB          (hiB),
  .loB          (loB)
);

// File: tb/test_hbridge_drive.sv
module test_hbridge_drive;
  localparam int DG = 25;
  localparam int DT = 2;

  logic clk = 1'b0;
  logic rst_n, hallIn, pwmIn, outEnable, thermalFault;
  logic hallCond, commStrobe, tachPullLow, hiA, loA, hiB, loB;
  int checks = 0;
  int errors = 0;
  int strobeSeen = 0;
  int overlapSeen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hbridge_drive #(.DEGLITCH_CYCLES(DG), .DEAD_CYCLES(DT)) i_hbridge_drive (
    .clk(clk), .rst_n(rst_n), .hallIn(hallIn), .pwmIn(pwmIn),
    .outEnable(outEnable), .thermalFault(thermalFault),
    .hallCond(hallCond), .commStrobe(commStrobe), .tachPullLow(tachPullLow),
    .hiA(hiA), .loA(loA), .hiB(hiB), .loB(loB)
  );

  always @(negedge clk) if (rst_n) begin
    if (commStrobe) strobeSeen++;
    if ((hiA && loA) || (hiB && loB)) overlapSeen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sw();
    return {hiA, loA, hiB, loB};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 switches {hiA,loA,hiB,loB}", sw(), 0);
    chk("R1 hallCond", hallCond, 0);
    chk("R1 commStrobe", commStrobe, 0);
    chk("R1 tachPullLow", tachPullLow, 1);
  endtask

  task automatic t_disabled_idle;
    step(3);
    chk("R8 outEnable low keeps bridge off", sw(), 0);
  endtask

  task automatic t_b_to_a;
    outEnable = 1'b1;
    step(1);
    chk("R10 first edge after enable", sw(), 4'b0110);
    step(5);
    chk("R6 B-to-A drive", sw(), 4'b0110);
    chk("R4 tach pulled low", tachPullLow, 1);
  endtask

  task automatic t_short_glitch;
    strobeSeen = 0;
    hallIn = 1'b1;
    step(DG - 1);
    hallIn = 1'b0;
    step(3);
    chk("R2 short excursion ignored", hallCond, 0);
    chk("R3 no strobe on glitch", strobeSeen, 0);
    chk("R6 drive unchanged by glitch", sw(), 4'b0110);
  endtask

  task automatic t_accept;
    strobeSeen = 0;
    hallIn = 1'b1;
    step(DG - 1);
    chk("R2 not yet accepted", hallCond, 0);
    step(1);
    chk("R2 accepted at edge DG", hallCond, 1);
    chk("R3 strobe high", commStrobe, 1);
    chk("R4 tach released", tachPullLow, 0);
    step(1);
    chk("R3 strobe one cycle", commStrobe, 0);
    step(6);
    chk("R3 single strobe", strobeSeen, 1);
    chk("R5 A-to-B drive", sw(), 4'b1001);
  endtask

  task automatic t_dead_a_to_b;
    pwmIn = 1'b0;
    step(1);
    chk("R9 leg B off after lo turns off", {hiB, loB}, 0);
    step(1);
    chk("R9 leg B still dead", {hiB, loB}, 0);
    step(1);
    chk("R9 leg B hi after dead time", {hiB, loB}, 2'b10);
    step(3);
    chk("R7 recirculation A-to-B", sw(), 4'b1010);
    pwmIn = 1'b1;
    step(1);
    chk("R9 leg B off after hi turns off", {hiB, loB}, 0);
    step(1);
    chk("R9 leg B lo still dead", {hiB, loB}, 0);
    step(1);
    chk("R9 leg B lo after dead time", {hiB, loB}, 2'b01);
  endtask

  task automatic t_enable_drop;
    outEnable = 1'b0;
    step(1);
    chk("R8 outEnable low -> all off", sw(), 0);
    step(4);
    outEnable = 1'b1;
    step(1);
    chk("R10 resume after enable", sw(), 4'b1001);
  endtask

  task automatic t_thermal;
    thermalFault = 1'b1;
    step(1);
    chk("R8 thermal -> all off", sw(), 0);
    step(4);
    chk("R8 thermal holds off", sw(), 0);
    thermalFault = 1'b0;
    step(1);
    chk("R10 resume after thermal clear", sw(), 4'b1001);
  endtask

  task automatic t_back_to_b;
    hallIn = 1'b0;
    step(DG + 6);
    chk("R2 return to 0", hallCond, 0);
    chk("R4 tach pulled low again", tachPullLow, 1);
    chk("R6 B-to-A after commutation", sw(), 4'b0110);
    pwmIn = 1'b0;
    step(6);
    chk("R7 recirculation B-to-A", sw(), 4'b1010);
    chk("R9 no leg overlap seen", overlapSeen, 0);
  endtask

  initial begin
    rst_n = 1'b0; hallIn = 1'b0; pwmIn = 1'b1;
    outEnable = 1'b0; thermalFault = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    t_disabled_idle();
    t_b_to_a();
    t_short_glitch();
    t_accept();
    t_dead_a_to_b();
    t_enable_drop();
    t_thermal();
    t_back_to_b();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule